// File: doc/BRIEF.md
# I2C Bit Timing Engine

This block turns bit-level requests from an I2C master's byte sequencer into open-drain SCL and SDA drive enables with programmable edge timing. One kernel-clock prescaler sets the tick length. The SCL low time, the SCL high time, the SDA hold delay after SCL falls and the SDA setup delay before SCL rises are each programmed separately in ticks. The sequencer asks for a START, a data bit (driven low or released) or a STOP, and it gets a one-cycle strobe at the end of each bit's high phase. Between bits the block holds SCL low, so the bus is parked until the next request arrives.

The high phase is timed from the SCL level that the block observes through a two-flop synchronizer, not from the moment it releases the line. A slave that holds SCL low therefore stretches the clock. Each high phase also carries a fixed synchronization overhead. The kernel clock must run at least four times faster than SCL. Clearing the enable input returns the block to idle and releases both lines.

Top module: `iic_bit_timer`

## Requirements
- R1: While `enable` is low, `scl_oe`, `sda_oe`, `bit_strobe` and `req_ready` are 0, and the clock after `enable` falls both drive enables are 0, even in the middle of a bit. After reset the block is idle with both lines released.
- R2: One tick lasts `presc`+1 kernel clocks, written P below. The prescaler restarts at every phase change, so each phase lasts an exact multiple of P plus one cycle.
- R3: Let R = max(`scl_low`+1, `hold_dly`+`setup_dly`+1). When the next request is already waiting as SCL is driven low, each bit and each STOP drives SCL low for R*P+2 cycles.
- R4: `req_bit`=0 drives SDA low and `req_bit`=1 releases it. A change of SDA appears `hold_dly`*P+2 cycles after `scl_oe` rises, and SDA never changes while a bit's SCL high phase is being timed.
- R5: From the cycle the SCL line reads high, it stays released for (`scl_high`+1)*P+4 cycles before `scl_oe` rises again. This holds whether or not a slave stretched the low phase, and SCL is never driven low while the synchronized line still reads low.
- R6: A START (`req_op`=2'b01) in idle drives SDA low while SCL is high. `scl_oe` rises (`scl_high`+1)*P+1 cycles later.
- R7: A STOP (`req_op`=2'b10) drives SDA low in the low phase. It releases SDA (`setup_dly`+1)*P+4 cycles after the SCL line reads high, and then the block is idle.
- R8: `bit_strobe` is a one-cycle pulse, once per data bit (`req_op`=2'b00), in the first cycle SCL is driven low after that bit's high phase. It never fires for START or STOP.
- R9: `req_ready` is 1 only when enabled and idle or parked. A request that does not fit the state is consumed with no effect: a bit or STOP in idle, or a START while parked. Code 2'b11 is ignored everywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low holds the block in reset |
| presc | input | 4 | Tick length minus one, in kernel clocks |
| scl_low | input | 8 | SCL low time minus one, in ticks |
| scl_high | input | 8 | SCL high time minus one, in ticks |
| hold_dly | input | 4 | SDA hold after SCL falls, in ticks |
| setup_dly | input | 4 | SDA setup before SCL rises, minus one, in ticks |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 bit, 01 START, 10 STOP |
| req_bit | input | 1 | Bit value: 0 drives SDA low, 1 releases |
| req_ready | output | 1 | Request accepted this cycle if valid |
| scl_in | input | 1 | Observed SCL line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| bit_strobe | output | 1 | End of a data bit |

## Verification
Every result has a fixed latency, counted from the drive-enable edge that starts it. The SDA change comes hold*P+2 cycles after `scl_oe` rises, and SCL release comes R*P+2 cycles after it. `scl_oe` rises again (H+1)*P+4 cycles after the line reads high, which includes three register stages of synchronizer and state. The STOP release comes (S+1)*P+4 cycles after the line reads high, and a START hold lasts (H+1)*P+1 cycles. The driver queues each of these intervals from the requirements when a request is accepted. A monitor samples on the falling clock, counts the same intervals on the lines and compares them in order. Stretching is injected just after a rising edge so that the synchronizer's capture cycle is fixed.

// File: rtl/iic_timer_pkg.sv
package iic_timer_pkg;

  // Request codes from the byte sequencer
  typedef enum logic [1:0] {
    OP_BIT   = 2'b00,
    OP_START = 2'b01,
    OP_STOP  = 2'b10,
    OP_NONE  = 2'b11
  } iic_op_e;

  // Bit engine phases
  typedef enum logic [2:0] {
    ST_IDLE,    // both lines released, bus free
    ST_START,   // SDA low, SCL high, timing START hold
    ST_PARK,    // SCL held low, waiting for a request
    ST_LOW,     // timing SCL low, SDA update, setup
    ST_WAITHI,  // SCL released, waiting to see it high
    ST_HIGH,    // timing SCL high
    ST_STOPSU   // SCL high, timing setup before SDA release
  } iic_state_e;

endpackage

// File: rtl/iic_tick_gen.sv
module iic_tick_gen #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] presc,
  output logic          tick
);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr || cnt_q >= presc) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q >= presc);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && presc != '0) |=> (!tick || presc == '0));

endmodule

// File: rtl/iic_line_sync.sv
module iic_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/iic_bit_timer.sv
module iic_bit_timer
  import iic_timer_pkg::*;
#(
  parameter int PW = 4,
  parameter int CW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] presc,
  input  logic [CW-1:0] scl_low,
  input  logic [CW-1:0] scl_high,
  input  logic [DW-1:0] hold_dly,
  input  logic [DW-1:0] setup_dly,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_bit,
  output logic          req_ready,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          bit_strobe
);

  localparam int CNTW = ((CW > DW + 1) ? CW : DW + 1) + 1;

  // Low phase in ticks: long enough for both the low count and hold+setup
  function automatic logic [CNTW-1:0] low_phase_ticks(
    input logic [CW-1:0] lo, input logic [DW-1:0] hd, input logic [DW-1:0] su);
    logic [CNTW-1:0] by_count, by_data;
    by_count = CNTW'(lo) + CNTW'(1);
    by_data  = CNTW'(hd) + CNTW'(su) + CNTW'(1);
    return (by_count > by_data) ? by_count : by_data;
  endfunction

  function automatic logic [CNTW-1:0] high_phase_ticks(input logic [CW-1:0] hi);
    return CNTW'(hi) + CNTW'(1);
  endfunction

  function automatic logic [CNTW-1:0] setup_ticks(input logic [DW-1:0] su);
    return CNTW'(su) + CNTW'(1);
  endfunction

  iic_state_e      state_q, state_n;
  logic [CNTW-1:0] lcnt_q;
  logic            sda_q, sda_n;
  logic            bit_q, bit_n;
  logic            stop_q, stop_n;
  logic            strobe_q, strobe_n;

  // Named internal events
  logic            tick, scl_hi, accept, phase_change, counting;
  logic [CNTW-1:0] low_span, high_span, setup_span, hold_span;
  iic_op_e         op;

  assign op         = iic_op_e'(req_op);
  assign low_span   = low_phase_ticks(scl_low, hold_dly, setup_dly);
  assign high_span  = high_phase_ticks(scl_high);
  assign setup_span = setup_ticks(setup_dly);
  assign hold_span  = CNTW'(hold_dly);

  assign req_ready  = enable && (state_q == ST_IDLE || state_q == ST_PARK);
  assign accept     = req_valid && req_ready;

  iic_tick_gen #(.PW(PW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (phase_change || !enable),
    .presc (presc),
    .tick  (tick)
  );

  iic_line_sync u_scl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (scl_hi)
  );

  always_comb begin
    state_n  = state_q;
    sda_n    = sda_q;
    bit_n    = bit_q;
    stop_n   = stop_q;
    strobe_n = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept && op == OP_START) begin
          state_n = ST_START;
          sda_n   = 1'b1;
        end
      end
      ST_START: begin
        if (lcnt_q >= high_span) state_n = ST_PARK;
      end
      ST_PARK: begin
        if (accept && op == OP_BIT) begin
          state_n = ST_LOW;
          bit_n   = req_bit;
          stop_n  = 1'b0;
        end else if (accept && op == OP_STOP) begin
          state_n = ST_LOW;
          bit_n   = 1'b0;
          stop_n  = 1'b1;
        end
      end
      ST_LOW: begin
        if (lcnt_q >= hold_span) sda_n = ~bit_q;
        if (lcnt_q >= low_span)  state_n = ST_WAITHI;
      end
      ST_WAITHI: begin
        if (scl_hi) state_n = stop_q ? ST_STOPSU : ST_HIGH;
      end
      ST_HIGH: begin
        if (lcnt_q >= high_span) begin
          state_n  = ST_PARK;
          strobe_n = 1'b1;
        end
      end
      ST_STOPSU: begin
        if (lcnt_q >= setup_span) begin
          state_n = ST_IDLE;
          sda_n   = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign phase_change = (state_n != state_q);
  assign counting     = (state_q == ST_START) || (state_q == ST_LOW) ||
                        (state_q == ST_HIGH)  || (state_q == ST_STOPSU);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      lcnt_q   <= '0;
      sda_q    <= 1'b0;
      bit_q    <= 1'b0;
      stop_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (!enable) begin
      state_q  <= ST_IDLE;
      lcnt_q   <= '0;
      sda_q    <= 1'b0;
      bit_q    <= 1'b0;
      stop_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      sda_q    <= sda_n;
      bit_q    <= bit_n;
      stop_q   <= stop_n;
      strobe_q <= strobe_n;
      if (phase_change)          lcnt_q <= '0;
      else if (counting && tick) lcnt_q <= lcnt_q + 1'b1;
    end
  end

  assign scl_oe     = (state_q == ST_PARK) || (state_q == ST_LOW);
  assign sda_oe     = sda_q;
  assign bit_strobe = strobe_q;

  // R1
  off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !sda_oe));

  // R4
  sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (state_q == ST_HIGH) |-> $stable(sda_q));

  // R5
  no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    (state_q == ST_WAITHI && !scl_hi) |=> !scl_oe);

  // R6
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    ($rose(sda_q) && !scl_oe) |-> $past(state_q == ST_IDLE));

  // R7
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    ($fell(sda_q) && !scl_oe) |-> $past(state_q == ST_STOPSU));

  // R8
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
    bit_strobe |-> (scl_oe && !$past(scl_oe)));

endmodule

// File: tb/test_iic_bit_timer.sv
module test_iic_bit_timer;

  localparam int K_HOLD = 0, K_LOW = 1, K_HIGH = 2, K_START = 3, K_STOP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] presc = '0;
  logic [7:0] scl_low = '0, scl_high = '0;
  logic [3:0] hold_dly = '0, setup_dly = '0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic       req_bit = 1'b0;
  logic       req_ready, scl_oe, sda_oe, bit_strobe;
  logic       stretch = 1'b0;
  wire        scl_line = !(scl_oe || stretch);

  int checks = 0, fails = 0;
  int exp_kind[$];
  int exp_val[$];
  int exp_strobes = 0, got_strobes = 0;
  int driven = 0;       // model of SDA pull (1 = low)
  int park_extra = 0;
  int stretch_len = 0;
  bit mon_en = 1'b0;

  // monitor state
  bit p_scl = 1'b0, p_sda = 1'b0, in_start = 1'b0, armed = 1'b0, ref_sda = 1'b0;
  int lo_cnt = 0, hi_cnt = 0;

  always #2 clk = ~clk;

  iic_bit_timer i_iic_bit_timer (
    .clk, .rst_n, .enable, .presc, .scl_low, .scl_high, .hold_dly, .setup_dly,
    .req_valid, .req_op, .req_bit, .req_ready, .scl_in(scl_line),
    .scl_oe, .sda_oe, .bit_strobe
  );

  function automatic string kname(input int k);
    case (k)
      K_HOLD:  return "R4 hold";
      K_LOW:   return "R3 low (R2 scale)";
      K_HIGH:  return "R5 high";
      K_START: return "R6 start";
      default: return "R7 stop";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic emit(input int k, input int v);
    if (exp_kind.size() == 0) begin
      check(1'b0, {kname(k), " unexpected event"}, v, -1);
    end else begin
      int ek, ev;
      ek = exp_kind.pop_front();
      ev = exp_val.pop_front();
      check(ek == k && ev == v, kname(ek), k * 1000 + v, ek * 1000 + ev);
    end
  endtask

  // slave clock stretching, driven just after the rising edge
  initial begin
    int left;
    left = 0;
    forever begin
      @(posedge clk);
      #1;
      if (scl_oe) begin
        stretch = (stretch_len > 0);
        left = stretch_len;
      end else if (left > 0) left--;
      else stretch = 1'b0;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (bit_strobe) begin
        got_strobes++;
        check(scl_oe && !p_scl, "R8 strobe position", int'(scl_oe), 1);
      end
      if (scl_oe && !p_scl) begin
        if (in_start) emit(K_START, hi_cnt);
        else          emit(K_HIGH, hi_cnt);
        in_start = 1'b0;
        lo_cnt = 1;
        ref_sda = sda_oe;
        armed = 1'b1;
      end else if (scl_oe) begin
        if (armed && sda_oe != ref_sda) begin
          emit(K_HOLD, lo_cnt);
          armed = 1'b0;
        end
        lo_cnt++;
      end
      if (!scl_oe && p_scl) emit(K_LOW, lo_cnt);
      if (!scl_oe && scl_line) begin
        if (sda_oe && !p_sda) begin
          in_start = 1'b1;
          hi_cnt = 1;
        end else begin
          if (!sda_oe && p_sda) emit(K_STOP, hi_cnt);
          hi_cnt++;
        end
      end else hi_cnt = 0;
    end
    p_scl = scl_oe;
    p_sda = sda_oe;
  end

  task automatic send_op(input logic [1:0] op, input logic b);
    @(negedge clk);
    req_valid = 1'b1;
    req_op = op;
    req_bit = b;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int pt();
    return int'(presc) + 1;
  endfunction

  function automatic int rt();
    int a, b;
    a = int'(scl_low) + 1;
    b = int'(hold_dly) + int'(setup_dly) + 1;
    return (a > b) ? a : b;
  endfunction

  task automatic push(input int k, input int v);
    exp_kind.push_back(k);
    exp_val.push_back(v);
  endtask

  task automatic do_start();
    send_op(2'b01, 1'b0);
    push(K_START, (int'(scl_high) + 1) * pt() + 1);
    driven = 1;
  endtask

  task automatic low_phase(input int nd);
    if (nd != driven) push(K_HOLD, int'(hold_dly) * pt() + 2 + park_extra);
    push(K_LOW, rt() * pt() + 2 + park_extra);
    park_extra = 0;
    driven = nd;
  endtask

  task automatic do_bit(input logic b);
    send_op(2'b00, b);
    low_phase(b ? 0 : 1);
    push(K_HIGH, (int'(scl_high) + 1) * pt() + 4);
    exp_strobes++;
  endtask

  task automatic do_stop();
    send_op(2'b10, 1'b0);
    low_phase(1);
    push(K_STOP, (int'(setup_dly) + 1) * pt() + 4);
    driven = 0;
  endtask

  task automatic drain();
    while (exp_kind.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!scl_oe && !sda_oe && req_ready, "R7 idle after stop", int'(scl_oe) + 2 * int'(sda_oe), 0);
  endtask

  task automatic set_cfg(input int p, input int l, input int h, input int hd, input int su, input int st);
    @(negedge clk);
    presc = 4'(p); scl_low = 8'(l); scl_high = 8'(h);
    hold_dly = 4'(hd); setup_dly = 4'(su); stretch_len = st;
  endtask

  initial begin
    int line_bad;
    repeat (3) @(negedge clk);
    // R1 reset state, disabled
    check(!scl_oe && !sda_oe && !bit_strobe && !req_ready, "R1 reset state",
          int'(scl_oe) + 2 * int'(sda_oe) + 4 * int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_ready, "R1 ready low while disabled", int'(req_ready), 0);
    enable = 1'b1;
    @(negedge clk);
    check(req_ready, "R9 ready in idle", int'(req_ready), 1);
    mon_en = 1'b1;

    // R9 ignored requests in idle
    set_cfg(1, 4, 4, 1, 1, 0);
    send_op(2'b00, 1'b0);
    send_op(2'b10, 1'b0);
    go_idle();
    line_bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (scl_oe || sda_oe) line_bad++;
    end
    check(line_bad == 0 && got_strobes == 0, "R9 bit/stop in idle ignored", line_bad, 0);

    // config A: P=2, equal low/high
    do_start();
    do_bit(1); do_bit(0); do_bit(1); do_bit(1);
    do_stop();
    go_idle();
    drain();

    // config B: P=1, low = 2x high, hold+setup dominates low time
    set_cfg(0, 5, 2, 2, 4, 0);
    do_start();
    do_bit(0); do_bit(0); do_bit(1); do_bit(0);
    do_stop();
    go_idle();
    drain();

    // config C: P=4, minimal counts, slave stretches, START while parked
    set_cfg(3, 1, 1, 0, 0, 5);
    do_start();
    do_bit(1);
    send_op(2'b01, 1'b0);   // ignored while parked (R9)
    park_extra = 1;
    do_bit(0);
    do_bit(1);
    do_stop();
    go_idle();
    drain();
    check(got_strobes == exp_strobes, "R8 strobe count", got_strobes, exp_strobes);

    // R1 disable in the middle of a bit
    set_cfg(1, 6, 6, 2, 1, 0);
    mon_en = 1'b0;
    send_op(2'b01, 1'b0);
    send_op(2'b00, 1'b0);
    go_idle();
    repeat (3) @(negedge clk);
    check(scl_oe && sda_oe, "R1 mid-bit lines driven before disable",
          int'(scl_oe) + 2 * int'(sda_oe), 3);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_oe && !sda_oe && !req_ready, "R1 disable releases lines",
          int'(scl_oe) + 2 * int'(sda_oe) + 4 * int'(req_ready), 0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check(!scl_oe && !sda_oe && req_ready, "R1 idle after re-enable",
          int'(scl_oe) + 2 * int'(sda_oe) + 4 * int'(!req_ready), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule